// File: doc/BRIEF.md
# Interrupt Context Shadow Register Unit

This block keeps a hardware copy of the processor core state that an interrupt service routine is likely to disturb. The state covers the accumulator, the flags register, the bank selector, two indirect pointers and the upper program-counter latch. When the core signals that it is entering an interrupt, every one of these registers is copied into a shadow bank in the same clock edge, and a stack push request for the return address goes out. When the core signals the interrupt return, the shadow copies are presented on the restore outputs for one cycle with a valid strobe. The core loads them back into its live registers, which discards any change the service routine made to the live registers.

Two flag bits are left out of the mechanism: the timeout flag and the power-down flag. They are never saved. On restore they always carry the live value, so a timeout or power-down event that occurs inside the service routine survives the return. Software can read and write the shadow copies through a byte-wide register port at fixed addresses in the highest register bank. A value written there is the value the core gets back on return, which lets a routine change the context it resumes into.

Top module: `ctxsh_top`

## Requirements
- R1: On a clock edge where `irq_enter` is high, the shadow copies of acc, flags, bank_sel, ptr0, ptr1 and pc_hi take the live input values present in that cycle.
- R2: `push_req` is high in exactly the cycles where `irq_enter` is high.
- R3: While `restore_valid` is high, the restore outputs for acc, bank_sel, ptr0, ptr1 and pc_hi equal the current shadow copies, and the restore flags equal the shadow flags in every bit except bits 4 and 3.
- R4: Flags bit 4 (timeout) and bit 3 (power-down) are neither saved nor written by software. They read back as 0 in the shadow, and `rs_flags` bits 4 and 3 equal `live_flags` bits 4 and 3 in the same cycle.
- R5: With defaults the shadow bytes sit in bank 31 at addresses 0xFE4 acc, 0xFE5 flags, 0xFE6 bank_sel (low 5 bits, others read 0), 0xFE7 pc_hi (low 7 bits, top bit reads 0), 0xFE8 ptr0 low byte, 0xFE9 ptr0 high byte, 0xFEA ptr1 low byte and 0xFEB ptr1 high byte. `sw_rdata` shows the addressed byte in the same cycle.
- R6: A software write with `sw_we` high to a shadow address, on an edge without `irq_enter`, updates that byte (masked as in R4/R5), and the new value is what the next restore presents.
- R7: When a software write and `irq_enter` coincide, the automatic save wins and the written data is discarded.
- R8: Writes to addresses outside the eight shadow addresses change no shadow byte, and reads there return 0.
- R9: `restore_valid` is high only in a cycle where `irq_ret` is high and `irq_enter` is low. It is low after reset while neither strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| live_acc | input | 8 | Live accumulator |
| live_flags | input | 8 | Live flags register |
| live_bank_sel | input | 5 | Live bank selector |
| live_ptr0 | input | 16 | Live indirect pointer 0 |
| live_ptr1 | input | 16 | Live indirect pointer 1 |
| live_pc_hi | input | 7 | Live upper program-counter latch |
| irq_enter | input | 1 | Interrupt entry strobe |
| irq_ret | input | 1 | Interrupt return strobe |
| sw_addr | input | 12 | Software register address |
| sw_we | input | 1 | Software write enable |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Software read data (combinational) |
| push_req | output | 1 | Return-address stack push request |
| restore_valid | output | 1 | Restore values valid this cycle |
| rs_acc | output | 8 | Restore accumulator |
| rs_flags | output | 8 | Restore flags |
| rs_bank_sel | output | 5 | Restore bank selector |
| rs_ptr0 | output | 16 | Restore pointer 0 |
| rs_ptr1 | output | 16 | Restore pointer 1 |
| rs_pc_hi | output | 7 | Restore upper program-counter latch |

## Verification
A software store to a shadow byte and the automatic save can land on the same clock edge. Both then target the same register. The bench provokes this by asserting `irq_enter` together with a write of a distinct value to the accumulator shadow, then reads the byte back and expects the live accumulator rather than the written data. The second overlap is entry and return strobed together: the bench expects the push request and no restore strobe.

// File: rtl/ctxsh_pkg.sv
package ctxsh_pkg;
  localparam int NSLOT   = 8;
  localparam int SLOT_AW = 3;

  typedef enum logic [SLOT_AW-1:0] {
    SL_ACC  = 3'd0,
    SL_FLG  = 3'd1,
    SL_BANK = 3'd2,
    SL_PCH  = 3'd3,
    SL_P0L  = 3'd4,
    SL_P0H  = 3'd5,
    SL_P1L  = 3'd6,
    SL_P1H  = 3'd7
  } slot_e;
endpackage

// File: rtl/ctxsh_decode.sv
module ctxsh_decode
  import ctxsh_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BANK     = 31,
  parameter int BANK_SZ  = 128,
  parameter int SLOT_OFS = 100
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit,
  output logic [SLOT_AW-1:0] slot
);
  localparam int BANK_AW = $clog2(BANK_SZ);
  localparam int BASE    = BANK * BANK_SZ + SLOT_OFS;

  logic [ADDR_W-1:0] rel;

  always_comb begin
    rel  = addr - ADDR_W'(BASE);
    hit  = (rel < ADDR_W'(NSLOT));
    slot = rel[SLOT_AW-1:0];
  end

  // R5
  always_comb begin
    in_bank_chk: assert (!hit || (int'(addr[ADDR_W-1:BANK_AW]) == BANK));
  end
endmodule

// File: rtl/ctxsh_store.sv
module ctxsh_store
  import ctxsh_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       save_en,
  input  logic                       wr_en,
  input  logic [SLOT_AW-1:0]         wr_slot,
  input  logic [DW-1:0]              wr_data,
  input  logic [NSLOT-1:0][DW-1:0]   live_bytes,
  input  logic [NSLOT-1:0][DW-1:0]   keep_mask,
  output logic [NSLOT-1:0][DW-1:0]   shd_bytes
);
  logic [NSLOT-1:0][DW-1:0] shd_q;
  logic [NSLOT-1:0][DW-1:0] shd_d;
  logic [NSLOT-1:0]         shd_en;

  assign shd_bytes = shd_q;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    // next-state: automatic save takes precedence over software store
    always_comb begin
      shd_en[i] = save_en | (wr_en & (wr_slot == SLOT_AW'(i)));
      if (save_en) shd_d[i] = live_bytes[i] & keep_mask[i];
      else         shd_d[i] = wr_data & keep_mask[i];
    end

    // shadow data carries no reset: contents are undefined until first save
    always_ff @(posedge clk) begin
      if (shd_en[i]) shd_q[i] <= shd_d[i];
    end

    // R1
    save_chk: assert property (@(posedge clk) disable iff (!rst_n)
      save_en |=> shd_q[i] == ($past(live_bytes[i]) & keep_mask[i]));

    // R6
    sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !save_en && wr_slot == SLOT_AW'(i))
        |=> shd_q[i] == ($past(wr_data) & keep_mask[i]));

    // R7
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && save_en && wr_slot == SLOT_AW'(i))
        |=> shd_q[i] != ($past(wr_data) & keep_mask[i]) ||
            shd_q[i] == ($past(live_bytes[i]) & keep_mask[i]));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!save_en && !(wr_en && wr_slot == SLOT_AW'(i))) |=> $stable(shd_q[i]));
  end
endmodule

// File: rtl/ctxsh_restore.sv
module ctxsh_restore
  import ctxsh_pkg::*;
#(
  parameter int DW      = 8,
  parameter int BANK_W  = 5,
  parameter int PTR_W   = 16,
  parameter int PCH_W   = 7,
  parameter int TO_BIT  = 4,
  parameter int PD_BIT  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ret_req,
  input  logic                     enter_req,
  input  logic [NSLOT-1:0][DW-1:0] shd_bytes,
  input  logic [DW-1:0]            live_flags,
  output logic                     valid,
  output logic [DW-1:0]            rs_acc,
  output logic [DW-1:0]            rs_flags,
  output logic [BANK_W-1:0]        rs_bank_sel,
  output logic [PTR_W-1:0]         rs_ptr0,
  output logic [PTR_W-1:0]         rs_ptr1,
  output logic [PCH_W-1:0]         rs_pc_hi
);
  localparam logic [DW-1:0] LIVE_KEEP = (DW'(1) << TO_BIT) | (DW'(1) << PD_BIT);

  always_comb begin
    valid       = ret_req & ~enter_req;
    rs_acc      = shd_bytes[SL_ACC];
    rs_flags    = (shd_bytes[SL_FLG] & ~LIVE_KEEP) | (live_flags & LIVE_KEEP);
    rs_bank_sel = shd_bytes[SL_BANK][BANK_W-1:0];
    rs_pc_hi    = shd_bytes[SL_PCH][PCH_W-1:0];
    rs_ptr0     = {shd_bytes[SL_P0H], shd_bytes[SL_P0L]};
    rs_ptr1     = {shd_bytes[SL_P1H], shd_bytes[SL_P1L]};
  end

  // R4
  live_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (rs_flags[TO_BIT] == live_flags[TO_BIT]) &&
              (rs_flags[PD_BIT] == live_flags[PD_BIT]));

  // R9
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ret_req && !enter_req);
endmodule

// File: rtl/ctxsh_top.sv
module ctxsh_top
  import ctxsh_pkg::*;
#(
  parameter int DW       = 8,
  parameter int BANK_W   = 5,
  parameter int PTR_W    = 16,
  parameter int PCH_W    = 7,
  parameter int TO_BIT   = 4,
  parameter int PD_BIT   = 3,
  parameter int ADDR_W   = 12,
  parameter int BANK     = 31,
  parameter int BANK_SZ  = 128,
  parameter int SLOT_OFS = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     live_acc,
  input  logic [DW-1:0]     live_flags,
  input  logic [BANK_W-1:0] live_bank_sel,
  input  logic [PTR_W-1:0]  live_ptr0,
  input  logic [PTR_W-1:0]  live_ptr1,
  input  logic [PCH_W-1:0]  live_pc_hi,
  input  logic              irq_enter,
  input  logic              irq_ret,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic              sw_we,
  input  logic [DW-1:0]     sw_wdata,
  output logic [DW-1:0]     sw_rdata,
  output logic              push_req,
  output logic              restore_valid,
  output logic [DW-1:0]     rs_acc,
  output logic [DW-1:0]     rs_flags,
  output logic [BANK_W-1:0] rs_bank_sel,
  output logic [PTR_W-1:0]  rs_ptr0,
  output logic [PTR_W-1:0]  rs_ptr1,
  output logic [PCH_W-1:0]  rs_pc_hi
);
  localparam logic [DW-1:0] ONES     = '1;
  localparam logic [DW-1:0] FLG_MASK = ~((DW'(1) << TO_BIT) | (DW'(1) << PD_BIT));
  localparam logic [DW-1:0] BNK_MASK = DW'((1 << BANK_W) - 1);
  localparam logic [DW-1:0] PCH_MASK = DW'((1 << PCH_W) - 1);
  localparam logic [NSLOT-1:0][DW-1:0] KEEP =
    {ONES, ONES, ONES, ONES, PCH_MASK, BNK_MASK, FLG_MASK, ONES};

  logic [NSLOT-1:0][DW-1:0] live_bytes;
  logic [NSLOT-1:0][DW-1:0] shd_bytes;
  logic                     dec_hit;
  logic [SLOT_AW-1:0]       dec_slot;
  logic                     wr_en;

  always_comb begin
    live_bytes          = '0;
    live_bytes[SL_ACC]  = live_acc;
    live_bytes[SL_FLG]  = live_flags;
    live_bytes[SL_BANK] = DW'(live_bank_sel);
    live_bytes[SL_PCH]  = DW'(live_pc_hi);
    live_bytes[SL_P0L]  = live_ptr0[DW-1:0];
    live_bytes[SL_P0H]  = live_ptr0[PTR_W-1:DW];
    live_bytes[SL_P1L]  = live_ptr1[DW-1:0];
    live_bytes[SL_P1H]  = live_ptr1[PTR_W-1:DW];
  end

  ctxsh_decode #(
    .ADDR_W(ADDR_W), .BANK(BANK), .BANK_SZ(BANK_SZ), .SLOT_OFS(SLOT_OFS)
  ) u_dec (
    .addr(sw_addr), .hit(dec_hit), .slot(dec_slot)
  );

  assign wr_en    = sw_we & dec_hit;
  assign push_req = irq_enter;

  ctxsh_store #(.DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .save_en(irq_enter), .wr_en(wr_en),
    .wr_slot(dec_slot), .wr_data(sw_wdata), .live_bytes(live_bytes),
    .keep_mask(KEEP), .shd_bytes(shd_bytes)
  );

  ctxsh_restore #(
    .DW(DW), .BANK_W(BANK_W), .PTR_W(PTR_W), .PCH_W(PCH_W),
    .TO_BIT(TO_BIT), .PD_BIT(PD_BIT)
  ) u_rst (
    .clk(clk), .rst_n(rst_n), .ret_req(irq_ret), .enter_req(irq_enter),
    .shd_bytes(shd_bytes), .live_flags(live_flags), .valid(restore_valid),
    .rs_acc(rs_acc), .rs_flags(rs_flags), .rs_bank_sel(rs_bank_sel),
    .rs_ptr0(rs_ptr0), .rs_ptr1(rs_ptr1), .rs_pc_hi(rs_pc_hi)
  );

  always_comb begin
    sw_rdata = dec_hit ? shd_bytes[dec_slot] : '0;
  end

  // R3
  rd_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_valid && dec_hit && dec_slot == SL_ACC) |-> rs_acc == sw_rdata);

  // R2
  push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |-> !restore_valid);
endmodule

// File: tb/tb_ctxsh_top.sv
module tb_ctxsh_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  live_acc, live_flags, sw_wdata, sw_rdata, rs_acc, rs_flags;
  logic [4:0]  live_bank_sel, rs_bank_sel;
  logic [15:0] live_ptr0, live_ptr1, rs_ptr0, rs_ptr1;
  logic [6:0]  live_pc_hi, rs_pc_hi;
  logic        irq_enter, irq_ret, sw_we, push_req, restore_valid;
  logic [11:0] sw_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  ctxsh_top dut (
    .clk(clk), .rst_n(rst_n), .live_acc(live_acc), .live_flags(live_flags),
    .live_bank_sel(live_bank_sel), .live_ptr0(live_ptr0), .live_ptr1(live_ptr1),
    .live_pc_hi(live_pc_hi), .irq_enter(irq_enter), .irq_ret(irq_ret),
    .sw_addr(sw_addr), .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .push_req(push_req), .restore_valid(restore_valid), .rs_acc(rs_acc),
    .rs_flags(rs_flags), .rs_bank_sel(rs_bank_sel), .rs_ptr0(rs_ptr0),
    .rs_ptr1(rs_ptr1), .rs_pc_hi(rs_pc_hi)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_live(input logic [7:0] a, input logic [7:0] f,
                          input logic [4:0] b, input logic [15:0] p0,
                          input logic [15:0] p1, input logic [6:0] pc);
    live_acc = a; live_flags = f; live_bank_sel = b;
    live_ptr0 = p0; live_ptr1 = p1; live_pc_hi = pc;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    sw_addr = a;
    #1;
    chk(sw_rdata === exp, req, 32'(sw_rdata), 32'(exp));
  endtask

  task automatic sw_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    sw_addr = a; sw_wdata = d; sw_we = 1'b1;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic pulse_enter();
    @(negedge clk);
    irq_enter = 1'b1;
    #1;
    chk(push_req === 1'b1, "R2 push during entry", 32'(push_req), 1);
    @(negedge clk);
    irq_enter = 1'b0;
    #1;
    chk(push_req === 1'b0, "R2 push after entry", 32'(push_req), 0);
  endtask

  task automatic t_reset();
    #1;
    chk(restore_valid === 1'b0, "R9 reset valid", 32'(restore_valid), 0);
    chk(push_req === 1'b0, "R2 reset push", 32'(push_req), 0);
  endtask

  task automatic t_entry();
    set_live(8'h5A, 8'hFF, 5'h13, 16'h1234, 16'hABCD, 7'h55);
    pulse_enter();
    set_live(8'h00, 8'h00, 5'h00, 16'h0000, 16'h0000, 7'h00);
    rd_chk(12'hFE4, 8'h5A, "R1 R5 acc");
    rd_chk(12'hFE5, 8'hE7, "R4 R5 flags excl");
    rd_chk(12'hFE6, 8'h13, "R1 R5 bank");
    rd_chk(12'hFE7, 8'h55, "R1 R5 pc_hi");
    rd_chk(12'hFE8, 8'h34, "R1 R5 ptr0 lo");
    rd_chk(12'hFE9, 8'h12, "R1 R5 ptr0 hi");
    rd_chk(12'hFEA, 8'hCD, "R1 R5 ptr1 lo");
    rd_chk(12'hFEB, 8'hAB, "R1 R5 ptr1 hi");
  endtask

  task automatic t_restore();
    @(negedge clk);
    irq_ret = 1'b1;
    #1;
    chk(restore_valid === 1'b1, "R9 valid on ret", 32'(restore_valid), 1);
    chk(rs_acc === 8'h5A, "R3 acc", 32'(rs_acc), 32'h5A);
    chk(rs_bank_sel === 5'h13, "R3 bank", 32'(rs_bank_sel), 32'h13);
    chk(rs_ptr0 === 16'h1234, "R3 ptr0", 32'(rs_ptr0), 32'h1234);
    chk(rs_ptr1 === 16'hABCD, "R3 ptr1", 32'(rs_ptr1), 32'hABCD);
    chk(rs_pc_hi === 7'h55, "R3 pc_hi", 32'(rs_pc_hi), 32'h55);
    chk(rs_flags === 8'hE7, "R4 flags live clear", 32'(rs_flags), 32'hE7);
    live_flags = 8'h10;
    #1;
    chk(rs_flags === 8'hF7, "R4 flags live timeout", 32'(rs_flags), 32'hF7);
    @(negedge clk);
    irq_ret = 1'b0;
    #1;
    chk(restore_valid === 1'b0, "R9 valid after ret", 32'(restore_valid), 0);
  endtask

  task automatic t_sw_write();
    sw_write(12'hFE4, 8'hC3);
    sw_write(12'hFEB, 8'h77);
    sw_write(12'hFE6, 8'hFF);
    sw_write(12'hFE5, 8'h18);
    rd_chk(12'hFE6, 8'h1F, "R6 bank masked");
    rd_chk(12'hFE5, 8'h00, "R4 flags sw write excl");
    @(negedge clk);
    live_flags = 8'h08;
    irq_ret = 1'b1;
    #1;
    chk(rs_acc === 8'hC3, "R6 acc restored", 32'(rs_acc), 32'hC3);
    chk(rs_ptr1 === 16'h77CD, "R6 ptr1 restored", 32'(rs_ptr1), 32'h77CD);
    chk(rs_bank_sel === 5'h1F, "R6 bank restored", 32'(rs_bank_sel), 32'h1F);
    chk(rs_flags === 8'h08, "R4 flags pd live", 32'(rs_flags), 32'h08);
    @(negedge clk);
    irq_ret = 1'b0;
  endtask

  task automatic t_collision();
    set_live(8'h66, 8'h81, 5'h02, 16'hBEEF, 16'h0F0F, 7'h7F);
    @(negedge clk);
    irq_enter = 1'b1; sw_addr = 12'hFE4; sw_wdata = 8'h99; sw_we = 1'b1;
    @(negedge clk);
    irq_enter = 1'b0; sw_we = 1'b0;
    rd_chk(12'hFE4, 8'h66, "R7 save wins acc");
    rd_chk(12'hFE9, 8'hBE, "R1 second pattern ptr0 hi");
    rd_chk(12'hFE7, 8'h7F, "R1 second pattern pc_hi");
  endtask

  task automatic t_bad_addr();
    sw_write(12'hFE3, 8'h11);
    sw_write(12'hFEC, 8'h22);
    sw_write(12'hF64, 8'h33);
    rd_chk(12'hFE3, 8'h00, "R8 below read 0");
    rd_chk(12'hFEC, 8'h00, "R8 above read 0");
    rd_chk(12'hF64, 8'h00, "R8 other bank read 0");
    rd_chk(12'hFE4, 8'h66, "R8 acc unchanged");
    rd_chk(12'hFEB, 8'h0F, "R8 ptr1 hi unchanged");
    rd_chk(12'hFE5, 8'h81, "R8 flags unchanged");
  endtask

  task automatic t_enter_and_ret();
    @(negedge clk);
    irq_enter = 1'b1; irq_ret = 1'b1;
    #1;
    chk(restore_valid === 1'b0, "R9 no valid with enter", 32'(restore_valid), 0);
    chk(push_req === 1'b1, "R2 push with ret", 32'(push_req), 1);
    @(negedge clk);
    irq_enter = 1'b0; irq_ret = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    irq_enter = 1'b0; irq_ret = 1'b0; sw_we = 1'b0;
    sw_addr = '0; sw_wdata = '0;
    set_live(8'h00, 8'h00, 5'h00, 16'h0000, 16'h0000, 7'h00);
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_entry();
    t_restore();
    t_sw_write();
    t_collision();
    t_bad_addr();
    t_enter_and_ret();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule